// File: doc/BRIEF.md
# Read-Response CRC-4 Checker

This block checks the integrity of a one-byte read exchange with a contactless memory tag. The reader sends a short read command, which is a single command bit of value one followed by the byte address. The tag answers with a 12-bit word. The low eight bits of that word are the data byte and the high four bits are a check nibble. The checker rebuilds the command bits together with the returned data byte, runs them through a 4-bit CRC one bit per clock, and compares the result with the received nibble.

A host pulses `start` with the address, the command length and the captured response. After a fixed number of cycles the block raises `done` for one cycle. At that point it presents the data byte and a `crc_ok` verdict, and both stay put until the next accepted start. Two command lengths are supported, 7 bits and 9 bits. They give a 6-bit address and an 8-bit address respectively.

Top module: `read_crc_checker`

## Requirements
- R1: After reset, `done`, `crc_ok` and `data_byte` are all zero.
- R2: A start accepted while idle produces exactly one `done` pulse of one cycle. It appears 15 clock edges after the accepting edge when `cmd_long`=0 (7-bit command) and 17 edges after it when `cmd_long`=1 (9-bit command).
- R3: When `done` is high, `data_byte` equals bits 7:0 of the response captured at the accepted start. It keeps that value until the next accepted start, which clears it to zero.
- R4: The register is preset to 0x5. Each input bit b updates the value c to (c>>1)^0xC when c[0]^b is 1, and to c>>1 otherwise. No final XOR is applied.
- R5: The bits are fed in this order, each field least significant bit first: one command bit of value 1, then the command length minus one low address bits, then the 8 data bits. `crc_ok` is 1 exactly when the result equals response bits 11:8.
- R6: With `cmd_long`=0, address bits 7:6 have no effect on the verdict.
- R7: `crc_ok` keeps its value from the `done` pulse until the next accepted start, which clears it to 0.
- R8: A `start` pulse while a check is running is ignored. The running check finishes with its own inputs and timing.
- R9: A response whose check nibble or data byte differs in any single bit from a consistent one gives `crc_ok`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check; sampled only while idle |
| cmd_long | input | 1 | 0: 7-bit command (6-bit address), 1: 9-bit command (8-bit address) |
| addr | input | 8 | Byte address used in the read command |
| rsp | input | 12 | Tag response: bits 11:8 check nibble, bits 7:0 data |
| data_byte | output | 8 | Data byte of the checked response |
| crc_ok | output | 1 | Received nibble matched the computed CRC |
| done | output | 1 | One-cycle pulse when the verdict is ready |

## Verification
The checker is driven with consistent responses in both command lengths over a sweep of addresses and data bytes. It is also driven with responses that have a single flipped bit, either in the check nibble or in the data byte. Together these separate a correct polynomial, preset and field order from near misses, since a wrong bit order or a wrong address width makes the consistent cases fail. In short mode, an address with its two upper bits set shows whether those bits leak into the stream. A second start issued mid-check, carrying different inputs, shows whether a running check can be disturbed. Latency is measured edge by edge for both lengths, and the outputs are watched for many idle cycles to confirm that the verdict holds.

// File: rtl/rdchk_pkg.sv
package rdchk_pkg;

    localparam int DATA_W    = 8;
    localparam int CRC_W     = 4;
    localparam int SHORT_CMD = 7;
    localparam int LONG_CMD  = 9;
    localparam int ADDR_W    = LONG_CMD - 1;
    localparam int SHORT_AW  = SHORT_CMD - 1;
    localparam int STREAM_W  = 1 + ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(STREAM_W + 1);
    localparam int RSP_W     = CRC_W + DATA_W;

    localparam logic [CRC_W-1:0] CRC_POLY   = 4'hC;
    localparam logic [CRC_W-1:0] CRC_PRESET = 4'h5;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic [CRC_W-1:0]  rx_crc;
        logic [DATA_W-1:0] data;
    } resp_t;

    typedef enum logic {
        CMD_SHORT = 1'b0,
        CMD_LONG  = 1'b1
    } cmd_len_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // One serial step of the reflected CRC.
    function automatic crc_t crc_step(crc_t c, logic b);
        crc_t sh;
        sh = c >> 1;
        if (c[0] ^ b)
            return sh ^ CRC_POLY;
        else
            return sh;
    endfunction

    // Number of serial bits for a command length.
    function automatic logic [CNT_W-1:0] stream_len(cmd_len_e m);
        if (m == CMD_LONG)
            return CNT_W'(LONG_CMD + DATA_W);
        else
            return CNT_W'(SHORT_CMD + DATA_W);
    endfunction

    // Serial stream, bit 0 first: command bit, address, data.
    function automatic logic [STREAM_W-1:0] build_stream(cmd_len_e m,
                                                         logic [ADDR_W-1:0] a,
                                                         logic [DATA_W-1:0] d);
        logic [STREAM_W-1:0] s;
        if (m == CMD_LONG)
            s = {d, a, 1'b1};
        else
            s = STREAM_W'({d, a[SHORT_AW-1:0], 1'b1});
        return s;
    endfunction

endpackage

// File: rtl/rdchk_seq.sv
module rdchk_seq
    import rdchk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cmd_long,
    output logic accept,
    output logic shift_en,
    output logic last_bit,
    output logic busy
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy     = (state_q == SEQ_RUN);
    assign accept   = start && !busy;
    assign shift_en = busy;
    assign last_bit = busy && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= stream_len(cmd_len_e'(cmd_long));
                    end
                end
                SEQ_RUN: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1))
                        state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R2: the counter stays inside the longest stream while running
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(LONG_CMD + DATA_W)));

    // R2: the last bit always ends the run
    assert_last_ends_R2: assert property (@(posedge clk) disable iff (rst)
        last_bit |=> !busy);

    // R8: a start during a run does not reload the counter
    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !last_bit) |=> (busy && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/rdchk_ser.sv
module rdchk_ser
    import rdchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic              cmd_long,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              bit_out
);

    logic [STREAM_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (load)
            sr_q <= build_stream(cmd_len_e'(cmd_long), addr, data);
        else if (shift)
            sr_q <= sr_q >> 1;
    end

    assign bit_out = sr_q[0];

    // R5: the first serial bit after a load is the command bit of value 1
    assert_cmd_bit_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> bit_out);

endmodule

// File: rtl/rdchk_crc.sv
module rdchk_crc
    import rdchk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic en,
    input  logic din,
    output crc_t crc_q,
    output crc_t crc_nxt
);

    assign crc_nxt = crc_step(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= CRC_PRESET;
        else if (init)
            crc_q <= CRC_PRESET;
        else if (en)
            crc_q <= crc_nxt;
    end

    // R4: every check begins from the preset value
    assert_preset_R4: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc_q == CRC_PRESET));

endmodule

// File: rtl/read_crc_checker.sv
module read_crc_checker
    import rdchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cmd_long,
    input  logic [7:0]  addr,
    input  logic [11:0] rsp,
    output logic [7:0]  data_byte,
    output logic        crc_ok,
    output logic        done
);

    logic  accept, shift_en, last_bit, busy, ser_bit;
    crc_t  crc_q, crc_nxt;
    resp_t rsp_q;
    logic  [DATA_W-1:0] data_q;
    logic  ok_q, done_q;

    rdchk_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_long (cmd_long),
        .accept   (accept),
        .shift_en (shift_en),
        .last_bit (last_bit),
        .busy     (busy)
    );

    rdchk_ser u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .shift    (shift_en),
        .cmd_long (cmd_long),
        .addr     (addr),
        .data     (rsp[DATA_W-1:0]),
        .bit_out  (ser_bit)
    );

    rdchk_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .init    (accept),
        .en      (shift_en),
        .din     (ser_bit),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= '0;
            data_q <= '0;
            ok_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_bit;
            if (accept) begin
                rsp_q  <= resp_t'(rsp);
                data_q <= '0;
                ok_q   <= 1'b0;
            end else if (last_bit) begin
                data_q <= rsp_q.data;
                ok_q   <= (crc_nxt == rsp_q.rx_crc);
            end
        end
    end

    assign data_byte = data_q;
    assign crc_ok    = ok_q;
    assign done      = done_q;

    // R2: done lasts one cycle
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the verdict moves only at an accepted start or at the last bit
    assert_ok_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!accept && !last_bit) |=> $stable(crc_ok));

    // R5: a pass verdict appears only together with done
    assert_ok_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_ok) |-> done);

    // R3: the data byte is stable while a check runs
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_bit) |=> $stable(data_byte));

endmodule

// File: tb/tb_read_crc_checker.sv
module tb_read_crc_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmd_long = 1'b0;
    logic [7:0]  addr = '0;
    logic [11:0] rsp = '0;
    logic [7:0]  data_byte;
    logic        crc_ok;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    read_crc_checker dut (
        .clk(clk), .rst(rst), .start(start), .cmd_long(cmd_long),
        .addr(addr), .rsp(rsp), .data_byte(data_byte), .crc_ok(crc_ok), .done(done)
    );

    function automatic logic [3:0] feed(logic [3:0] c, logic b);
        if (c[0] ^ b) return (c >> 1) ^ 4'hC;
        return c >> 1;
    endfunction

    function automatic logic [3:0] ref_crc(logic lng, logic [7:0] a, logic [7:0] d);
        logic [3:0] c;
        int na;
        c  = 4'h5;
        na = lng ? 8 : 6;
        c  = feed(c, 1'b1);
        for (int i = 0; i < na; i++) c = feed(c, a[i]);
        for (int i = 0; i < 8; i++) c = feed(c, d[i]);
        return c;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Start a check and return the edge count at which done was seen.
    task automatic run(input logic lng, input logic [7:0] a, input logic [11:0] r,
                       output int lat);
        @(negedge clk);
        cmd_long = lng; addr = a; rsp = r; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = -1;
        for (int i = 1; i <= 30; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) begin
                lat = i;
                break;
            end
        end
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R1 done", done, 0);
        check(crc_ok == 1'b0, "R1 crc_ok", crc_ok, 0);
        check(data_byte == 8'h00, "R1 data_byte", data_byte, 0);
    endtask

    task automatic t_good(input logic lng, input logic [7:0] a, input logic [7:0] d);
        int lat;
        logic [3:0] c;
        c = ref_crc(lng, a, d);
        run(lng, a, {c, d}, lat);
        check(lat == (lng ? 17 : 15), "R2 latency", lat, lng ? 17 : 15);
        check(crc_ok == 1'b1, "R5 good crc", crc_ok, 1);
        check(data_byte == d, "R3 data", data_byte, d);
        @(negedge clk);
        check(done == 1'b0, "R2 single pulse", done, 0);
    endtask

    task automatic t_bad(input logic lng, input logic [7:0] a, input logic [7:0] d, input int flip);
        int lat;
        logic [11:0] r;
        r = {ref_crc(lng, a, d), d};
        r[flip] = ~r[flip];
        run(lng, a, r, lat);
        check(crc_ok == 1'b0, "R9 corrupted bit", crc_ok, 0);
        check(data_byte == r[7:0], "R3 data bad", data_byte, r[7:0]);
    endtask

    task automatic t_short_upper;
        int lat;
        logic [7:0] d;
        d = 8'h3C;
        run(1'b0, 8'hC5, {ref_crc(1'b0, 8'h05, d), d}, lat);
        check(crc_ok == 1'b1, "R6 upper addr ignored", crc_ok, 1);
        run(1'b1, 8'hC5, {ref_crc(1'b0, 8'h05, d), d}, lat);
        check(crc_ok == (ref_crc(1'b1, 8'hC5, d) == ref_crc(1'b0, 8'h05, d)),
              "R5 long uses all bits", crc_ok, 0);
    endtask

    task automatic t_busy_start;
        logic [7:0] d;
        logic [3:0] c;
        int seen;
        d = 8'hA7;
        c = ref_crc(1'b1, 8'h9E, d);
        @(negedge clk);
        cmd_long = 1'b1; addr = 8'h9E; rsp = {c, d}; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        seen = -1;
        for (int i = 1; i <= 30; i++) begin
            if (i == 5) begin
                cmd_long = 1'b0; addr = 8'h11; rsp = 12'h0FF; start = 1'b1;
            end
            if (i == 6) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (done && seen < 0) seen = i;
        end
        check(seen == 17, "R8 timing kept", seen, 17);
        check(crc_ok == 1'b1, "R8 verdict kept", crc_ok, 1);
        check(data_byte == d, "R8 data kept", data_byte, d);
    endtask

    task automatic t_hold;
        int lat;
        logic [7:0] d;
        logic good;
        d = 8'h5A;
        run(1'b0, 8'h2B, {ref_crc(1'b0, 8'h2B, d), d}, lat);
        good = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (crc_ok !== 1'b1 || data_byte !== d || done !== 1'b0) good = 1'b0;
        end
        check(good, "R7 verdict held", crc_ok, 1);
        @(negedge clk);
        cmd_long = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(crc_ok == 1'b0, "R7 cleared at start", crc_ok, 0);
        check(data_byte == 8'h00, "R3 cleared at start", data_byte, 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // R4 R5 sweep in both lengths
        for (int k = 0; k < 12; k++) begin
            t_good(1'b0, 8'(k * 21), 8'(k * 37 + 3));
            t_good(1'b1, 8'(k * 19 + 128), 8'(255 - k * 13));
        end
        t_good(1'b1, 8'hFF, 8'hFF);
        t_good(1'b0, 8'h00, 8'h00);
        for (int f = 0; f < 12; f++) begin
            t_bad(1'b0, 8'h1D, 8'hC3, f);
            t_bad(1'b1, 8'hB2, 8'h47, f);
        end
        t_short_upper();
        t_busy_start();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule